// File: doc/BRIEF.md
# Synchronous Rectifier Skew Generator

This block sits after the bridge timing generator of a zero-voltage-switching full-bridge controller. It receives the two trailing-edge-modulated lower drives and the two fixed 50% upper drives. It produces two synchronous-rectifier (SR) drives, each the logical complement of one lower drive. Because of that pairing, the SR output that complements the left lower drive is high while the right lower pulse is on, and the reverse holds. During freewheeling, when neither lower drive is on, both SR outputs are high.

A signed skew code sets the phase of the SR group against the bridge group, counted in system clock cycles. Codes inside a small band around zero give no skew. A positive code beyond the band holds back only the SR outputs. A negative code beyond the band holds back the two lower drives and the two upper drives by one common amount, so the upper-to-lower resonant spacing does not change, and the SR outputs then lead. The code-to-cycles map starts at a nonzero minimum just outside the band and rises quadratically to a maximum at the end of the range. This gives fine steps for short skews. The bridge-group delay is capped at 90% of the programmed deadtime. The code is taken only at clock edges where both lower inputs are low, so a skew change never cuts into a live pulse.

Top module: `sr_skew_gen`

## Requirements
- R1: With zero skew in effect, sr_l_o equals the inverse of pwm_l_o and sr_r_o equals the inverse of pwm_r_o in every cycle.
- R2: A code c with |c| <= DEADBAND (default 2) gives zero skew. All six outputs follow the inputs in the same cycle, with no register between them.
- R3: A code c > DEADBAND delays sr_l_o and sr_r_o by map(c) cycles (sr_l_o(t) = not pwm_l_i(t-d)). The four bridge outputs stay undelayed.
- R4: A code c < -DEADBAND delays pwm_l_o, pwm_r_o, up_l_o and up_r_o by one common amount d. The SR outputs then follow the undelayed inverted inputs.
- R5: map(c) = MIN_DLY + floor(m*m*(MAX_DLY-MIN_DLY)/(S*S)), with m = |c|-DEADBAND clamped to S = 2^(CODE_W-1)-1-DEADBAND. With the defaults, codes 3, 10, 20 and 31 give 4, 5, 14 and 30 cycles.
- R6: The bridge-group delay is min(map(c), floor(9*DT_CYCLES/10)). With the defaults the code -32 gives 18 cycles.
- R7: A new code takes effect only at a clock edge where pwm_l_i and pwm_r_i are both low. A code change while a lower input is high leaves the outputs unchanged until such an edge.
- R8: After reset both delays are zero and the delay history holds zeros. With all inputs low, the bridge outputs are low and both SR outputs are high.
- R9: When both lower inputs stay low (zero duty), both SR outputs stay high for any skew code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one skew step is one cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_l_i | input | 1 | Left lower bridge drive from the timing generator |
| pwm_r_i | input | 1 | Right lower bridge drive from the timing generator |
| up_l_i | input | 1 | Left upper 50% drive |
| up_r_i | input | 1 | Right upper 50% drive |
| skew_code_i | input | CODE_W | Signed skew code, two's complement |
| pwm_l_o | output | 1 | Left lower drive after bridge-group skew |
| pwm_r_o | output | 1 | Right lower drive after bridge-group skew |
| up_l_o | output | 1 | Left upper drive after bridge-group skew |
| up_r_o | output | 1 | Right upper drive after bridge-group skew |
| sr_l_o | output | 1 | SR drive, inverse of the left lower drive after SR-group skew |
| sr_r_o | output | 1 | SR drive, inverse of the right lower drive after SR-group skew |

## Verification
The assertions hold on every cycle:
- that the skew applies to only one group at a time, with the undelayed group following its live input;
- that the complement pairing holds whenever no skew is in effect;
- that a nonzero delay never falls below the minimum step and the bridge-group delay never exceeds the deadtime cap;
- that the latched delays change only after an edge with both lower inputs low.

The exact cycle counts from the code-to-cycles map, the quadratic spacing of the steps, and the postponement of a code changed mid-pulse can only be shown by the bench's scenarios. Those scenarios sweep the codes against a history-based reference model. The same applies to the SR outputs staying high under zero duty at both extreme codes.

// File: rtl/sr_skew_pkg.sv
package sr_skew_pkg;

  // Quadratic code-to-cycles map: fine steps near the band, coarse near the ends.
  function automatic int skew_map(input int mag, input int span,
                                  input int dmin, input int dmax);
    int m;
    m = (mag > span) ? span : mag;
    if (m <= 0) return 0;
    return dmin + (m * m * (dmax - dmin)) / (span * span);
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/sr_skew_ctrl.sv
module sr_skew_ctrl #(
  parameter int CODE_W    = 6,
  parameter int DEADBAND  = 2,
  parameter int MIN_DLY   = 4,
  parameter int MAX_DLY   = 30,
  parameter int DT_CYCLES = 20,
  parameter int DW        = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     latch_en,
  input  logic signed [CODE_W-1:0] code,
  output logic [DW-1:0]            pri_dly,
  output logic [DW-1:0]            sr_dly
);
  import sr_skew_pkg::*;

  localparam int SPAN    = (2 ** (CODE_W - 1)) - 1 - DEADBAND;
  localparam int LIMIT   = (DT_CYCLES * 9) / 10;
  localparam int PRI_CAP = (LIMIT < MAX_DLY) ? LIMIT : MAX_DLY;

  int code_v, mag, mapped, pri_next, sr_next;

  always_comb begin
    code_v   = int'(code);
    mag      = ((code_v < 0) ? -code_v : code_v) - DEADBAND;
    mapped   = skew_map(mag, SPAN, MIN_DLY, MAX_DLY);
    pri_next = (code_v < -DEADBAND) ? imin(mapped, PRI_CAP) : 0;
    sr_next  = (code_v > DEADBAND) ? mapped : 0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_dly <= '0;
      sr_dly  <= '0;
    end else if (latch_en) begin
      pri_dly <= DW'(pri_next);
      sr_dly  <= DW'(sr_next);
    end
  end
endmodule

// File: rtl/sr_hist_line.sv
module sr_hist_line #(
  parameter int W     = 4,
  parameter int DEPTH = 30
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W-1:0]              d,
  output logic [DEPTH-1:0][W-1:0]   hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else begin
      for (int j = DEPTH - 1; j > 0; j--) hist[j] <= hist[j-1];
      hist[0] <= d;
    end
  end
endmodule

// File: rtl/sr_delay_tap.sv
module sr_delay_tap #(
  parameter int W     = 4,
  parameter int DEPTH = 30,
  parameter int DW    = 5
) (
  input  logic [W-1:0]            live,
  input  logic [DEPTH-1:0][W-1:0] hist,
  input  logic [DW-1:0]           sel,
  output logic [W-1:0]            q
);
  always_comb begin
    q = live;
    for (int j = 0; j < DEPTH; j++)
      if (int'(sel) == j + 1) q = hist[j];
  end
endmodule

// File: rtl/sr_skew_gen.sv
module sr_skew_gen #(
  parameter int CODE_W    = 6,
  parameter int DEADBAND  = 2,
  parameter int MIN_DLY   = 4,
  parameter int MAX_DLY   = 30,
  parameter int DT_CYCLES = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pwm_l_i,
  input  logic                     pwm_r_i,
  input  logic                     up_l_i,
  input  logic                     up_r_i,
  input  logic signed [CODE_W-1:0] skew_code_i,
  output logic                     pwm_l_o,
  output logic                     pwm_r_o,
  output logic                     up_l_o,
  output logic                     up_r_o,
  output logic                     sr_l_o,
  output logic                     sr_r_o
);
  localparam int DW    = $clog2(MAX_DLY + 1);
  localparam int DEPTH = MAX_DLY;
  localparam int BW    = 4;   // {up_l, up_r, pwm_l, pwm_r}
  localparam int LW    = 2;   // lower drives only

  logic [BW-1:0]              bundle;
  logic [DEPTH-1:0][BW-1:0]   hist;
  logic [DEPTH-1:0][LW-1:0]   hist_low;
  logic [BW-1:0]              pri_q;
  logic [LW-1:0]              sr_q;
  logic [DW-1:0]              pri_dly, sr_dly;
  logic                       deadtime;

  assign bundle   = {up_l_i, up_r_i, pwm_l_i, pwm_r_i};
  assign deadtime = !pwm_l_i && !pwm_r_i;

  sr_skew_ctrl #(
    .CODE_W(CODE_W), .DEADBAND(DEADBAND), .MIN_DLY(MIN_DLY),
    .MAX_DLY(MAX_DLY), .DT_CYCLES(DT_CYCLES), .DW(DW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .latch_en(deadtime), .code(skew_code_i),
    .pri_dly(pri_dly), .sr_dly(sr_dly)
  );

  sr_hist_line #(.W(BW), .DEPTH(DEPTH)) u_line (
    .clk(clk), .rst_n(rst_n), .d(bundle), .hist(hist)
  );

  for (genvar j = 0; j < DEPTH; j++) begin : g_low
    assign hist_low[j] = hist[j][LW-1:0];
  end

  sr_delay_tap #(.W(BW), .DEPTH(DEPTH), .DW(DW)) u_pri_tap (
    .live(bundle), .hist(hist), .sel(pri_dly), .q(pri_q)
  );

  sr_delay_tap #(.W(LW), .DEPTH(DEPTH), .DW(DW)) u_sr_tap (
    .live(bundle[LW-1:0]), .hist(hist_low), .sel(sr_dly), .q(sr_q)
  );

  assign {up_l_o, up_r_o, pwm_l_o, pwm_r_o} = pri_q;
  assign sr_l_o = ~sr_q[1];
  assign sr_r_o = ~sr_q[0];
endmodule

// File: rtl/sr_skew_chk.sv
module sr_skew_chk #(
  parameter int MIN_DLY   = 4,
  parameter int DT_CYCLES = 20,
  parameter int DW        = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwm_l_i,
  input logic          pwm_r_i,
  input logic          pwm_l_o,
  input logic          pwm_r_o,
  input logic          sr_l_o,
  input logic          sr_r_o,
  input logic [DW-1:0] pri_dly,
  input logic [DW-1:0] sr_dly
);
  localparam int LIMIT = (DT_CYCLES * 9) / 10;

  assert_bridge_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_dly != 0) |-> (pwm_l_o == pwm_l_i && pwm_r_o == pwm_r_i));

  assert_sr_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_dly != 0) |-> (sr_l_o == !pwm_l_i && sr_r_o == !pwm_r_i));

  assert_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_dly == 0 && sr_dly == 0) |-> (sr_l_o == !pwm_l_o && sr_r_o == !pwm_r_o));

  assert_min_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pri_dly != 0) |-> (int'(pri_dly) >= MIN_DLY)) and
    ((sr_dly != 0) |-> (int'(sr_dly) >= MIN_DLY)));

  assert_pri_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pri_dly) <= LIMIT);

  assert_latch_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pri_dly, sr_dly}) |-> $past(!pwm_l_i && !pwm_r_i));
endmodule

bind sr_skew_gen sr_skew_chk #(
  .MIN_DLY(MIN_DLY), .DT_CYCLES(DT_CYCLES), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_l_i(pwm_l_i), .pwm_r_i(pwm_r_i),
  .pwm_l_o(pwm_l_o), .pwm_r_o(pwm_r_o), .sr_l_o(sr_l_o), .sr_r_o(sr_r_o),
  .pri_dly(pri_dly), .sr_dly(sr_dly)
);

// File: tb/tb_sr_skew_gen.sv
module tb_sr_skew_gen;
  localparam int CODE_W = 6, DEADBAND = 2, MIN_DLY = 4, MAX_DLY = 30, DT_CYCLES = 20;
  localparam int HALF = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pl = 1'b0, pr = 1'b0, ul = 1'b0, ur = 1'b0;
  logic signed [CODE_W-1:0] sk = '0;
  logic pwm_l_o, pwm_r_o, up_l_o, up_r_o, sr_l_o, sr_r_o;

  int checks = 0, errors = 0;
  int m_pri = 0, m_sr = 0;
  bit done = 0;
  bit q_pl[$], q_pr[$], q_ul[$], q_ur[$];

  always #5 clk = ~clk;

  sr_skew_gen #(.CODE_W(CODE_W), .DEADBAND(DEADBAND), .MIN_DLY(MIN_DLY),
                .MAX_DLY(MAX_DLY), .DT_CYCLES(DT_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_l_i(pl), .pwm_r_i(pr), .up_l_i(ul), .up_r_i(ur),
    .skew_code_i(sk), .pwm_l_o(pwm_l_o), .pwm_r_o(pwm_r_o), .up_l_o(up_l_o),
    .up_r_o(up_r_o), .sr_l_o(sr_l_o), .sr_r_o(sr_r_o));

  // Reference: cycles grow with the square of the distance past the band.
  function automatic int ref_cycles(input int c);
    int m, span;
    longint num;
    span = (1 <<< (CODE_W - 1)) - 1 - DEADBAND;
    m = (c < 0 ? -c : c) - DEADBAND;
    if (m > span) m = span;
    num = longint'(m) * m * (MAX_DLY - MIN_DLY);
    return MIN_DLY + int'(num / (span * span));
  endfunction

  always @(posedge clk) begin
    if (rst_n && !pl && !pr) begin
      if (int'(sk) > DEADBAND) begin
        m_sr <= ref_cycles(int'(sk)); m_pri <= 0;
      end else if (int'(sk) < -DEADBAND) begin
        m_sr <= 0;
        m_pri <= (ref_cycles(int'(sk)) > (9 * DT_CYCLES) / 10) ?
                 (9 * DT_CYCLES) / 10 : ref_cycles(int'(sk));
      end else begin
        m_sr <= 0; m_pri <= 0;
      end
    end
  end

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic drive_cycle(input bit nul, input bit nur, input bit npl, input bit npr,
                             input string tag);
    int n, ip, is_;
    bit e_pl, e_pr, e_ul, e_ur, s_pl, s_pr;
    @(negedge clk);
    ul = nul; ur = nur; pl = npl; pr = npr;
    q_ul.push_back(nul); q_ur.push_back(nur); q_pl.push_back(npl); q_pr.push_back(npr);
    #1;
    n = q_pl.size() - 1;
    ip = n - m_pri; is_ = n - m_sr;
    e_pl = (ip >= 0) ? q_pl[ip] : 1'b0;
    e_pr = (ip >= 0) ? q_pr[ip] : 1'b0;
    e_ul = (ip >= 0) ? q_ul[ip] : 1'b0;
    e_ur = (ip >= 0) ? q_ur[ip] : 1'b0;
    s_pl = (is_ >= 0) ? q_pl[is_] : 1'b0;
    s_pr = (is_ >= 0) ? q_pr[is_] : 1'b0;
    check(tag, {up_l_o, up_r_o, pwm_l_o, pwm_r_o, sr_l_o, sr_r_o},
          {e_ul, e_ur, e_pl, e_pr, ~s_pl, ~s_pr});
  endtask

  task automatic run_half(input bit side, input int on_len, input string tag,
                          input bit chg, input logic signed [CODE_W-1:0] new_code);
    for (int i = 0; i < HALF; i++) begin
      if (chg && i == 5) sk = new_code;
      drive_cycle(!side, side, !side && i >= 2 && i < 2 + on_len,
                  side && i >= 2 && i < 2 + on_len, tag);
    end
  endtask

  task automatic run_phase(input int code, input int on_len, input string tag);
    sk = CODE_W'(code);
    for (int h = 0; h < 4; h++) run_half(h[0], on_len, tag, 1'b0, '0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R8: reset state with zero inputs
    check("R8 reset", {up_l_o, up_r_o, pwm_l_o, pwm_r_o, sr_l_o, sr_r_o}, 6'b000011);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 after release", {up_l_o, up_r_o, pwm_l_o, pwm_r_o, sr_l_o, sr_r_o}, 6'b000011);

    run_phase(0, 12, "R1 R2 zero code");
    run_phase(2, 12, "R2 band edge +");
    run_phase(-2, 12, "R2 band edge -");
    run_phase(3, 12, "R3 R5 first positive step");
    run_phase(10, 12, "R3 R5 code 10");
    run_phase(20, 15, "R3 R5 code 20");
    run_phase(31, 18, "R3 R5 top code");
    run_phase(-3, 12, "R4 R5 first negative step");
    run_phase(-20, 16, "R4 negative code");
    run_phase(-32, 18, "R6 capped bridge delay");

    // R7: code changed while a lower drive is high
    sk = CODE_W'(10);
    run_half(1'b0, 12, "R7 setup", 1'b0, '0);
    run_half(1'b1, 12, "R7 mid-pulse change", 1'b1, CODE_W'(-20));
    run_half(1'b0, 12, "R7 after deadtime", 1'b0, '0);
    sk = CODE_W'(31);
    run_half(1'b1, 14, "R7 mid-pulse change back", 1'b1, CODE_W'(3));
    run_half(1'b0, 14, "R7 settle", 1'b0, '0);

    // R9: zero duty keeps SR high at both extremes
    run_phase(31, 0, "R9 zero duty +");
    run_phase(-32, 0, "R9 zero duty -");
    #1;
    check("R9 SR high", {4'b0000, sr_l_o, sr_r_o}, 6'b000011);

    run_phase(0, 10, "R1 R2 return to zero");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule